// File: doc/BRIEF.md
# Warp Issue Selector

This block picks, in every clock cycle, at most one warp to issue its next instruction on a multiprocessor. Each warp slot is described by three inputs: a valid bit saying the slot holds a resident warp, a ready pulse saying the warp's next instruction has all its operands available, and a priority value. All threads of the chosen warp then execute the same instruction. That execution happens outside this block.

The selector keeps one operand-ready state bit per slot. A ready pulse sets the bit. Issuing the warp clears it, so the warp waits until it is marked ready again. A slot is eligible when it is valid and its ready state bit is set. The issue decision is combinational from the current state and inputs, so a different warp can be picked in every cycle at no cost. A warp that is stalled therefore never holds the issue slot. When nothing is eligible, an idle flag is raised instead of a grant.

The default of 24 slots covers three resident blocks of 256 threads. Each such block is split into eight warps of 32 threads.

Top module: `warp_issue_sel`

## Requirements
- R1: After reset every ready state bit is clear, so `issue_vld` is 0 and `idle` is 1 even when all slots are valid.
- R2: At most one warp is issued per cycle. `issue_slot` gives its index. `issue_vld` and `idle` are always complementary.
- R3: When no slot is eligible, `issue_vld` is 0, `idle` is 1 and `issue_slot` reads 0.
- R4: A slot is eligible only when `slot_valid[i]` is 1 and its ready state bit is set. A slot whose state bit is clear is never issued.
- R5: Among eligible slots, the one with the numerically largest priority field is issued. Slot i's priority occupies `slot_prio[i*PRIO_W +: PRIO_W]`.
- R6: Among eligible slots that share the largest priority, the lowest slot index is issued.
- R7: Issuing a slot clears its ready state bit from the next cycle on, unless it is set again by a pulse.
- R8: A pulse on `slot_ready[i]` sets slot i's state bit from the next cycle on. This also holds when slot i is issued in the same cycle: the set wins over the clear.
- R9: Issue can move to a different warp in the very next cycle with no idle cycle between, whenever another slot is eligible.
- R10: A ready state bit recorded while a slot is invalid is kept. The slot becomes eligible as soon as `slot_valid[i]` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | NUM_SLOTS | Slot holds a resident warp |
| slot_ready | input | NUM_SLOTS | Pulse: the slot's next instruction has its operands ready |
| slot_prio | input | NUM_SLOTS*PRIO_W | Packed per-slot priority, larger value wins |
| issue_vld | output | 1 | A warp is issued this cycle |
| issue_slot | output | IDX_W | Index of the issued slot |
| idle | output | 1 | No slot is eligible this cycle |

## Verification
An issue can clear a slot's ready bit in the same cycle that a ready pulse arrives for that same slot. In that case the set must take priority. The bench provokes this with a directed case that pulses the slot being issued and expects it to win again in the next cycle. Random stimulus also pulses ready on about a quarter of the slots each cycle, so the collision recurs often. Every cycle is judged against a bench model of the ready bits that applies the clear and then the set.

// File: rtl/warp_issue_sel.sv
module warp_issue_sel #(
  parameter int NUM_SLOTS = 24,
  parameter int PRIO_W    = 3,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS-1:0]        slot_valid,
  input  logic [NUM_SLOTS-1:0]        slot_ready,
  input  logic [NUM_SLOTS*PRIO_W-1:0] slot_prio,
  output logic                        issue_vld,
  output logic [IDX_W-1:0]            issue_slot,
  output logic                        idle
);

  logic [NUM_SLOTS-1:0] rdy_q;
  logic [NUM_SLOTS-1:0] elig;
  logic [NUM_SLOTS-1:0] grant;
  logic                 found;
  logic [PRIO_W-1:0]    best_prio;
  logic [IDX_W-1:0]     best_idx;

  assign elig = slot_valid & rdy_q;

  always_comb begin
    found     = 1'b0;
    best_prio = '0;
    best_idx  = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (elig[i] && (!found || slot_prio[i*PRIO_W +: PRIO_W] > best_prio)) begin
        found     = 1'b1;
        best_prio = slot_prio[i*PRIO_W +: PRIO_W];
        best_idx  = IDX_W'(i);
      end
    end
  end

  assign issue_vld  = found;
  assign issue_slot = best_idx;
  assign idle       = ~found;
  assign grant      = found ? ({{(NUM_SLOTS-1){1'b0}}, 1'b1} << best_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= '0;
    else        rdy_q <= (rdy_q & ~grant) | slot_ready;
  end

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r4_issue_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> (slot_valid[issue_slot] && rdy_q[issue_slot]));

  a_r3_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> ((slot_valid & rdy_q) == '0));

  a_r7_clear_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && !slot_ready[issue_slot]) |=> !rdy_q[$past(issue_slot)]);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      slot_ready[g] |=> rdy_q[g]);
  end

endmodule

// File: tb/tb_warp_issue_sel.sv
module tb_warp_issue_sel;
  localparam int N  = 24;
  localparam int PW = 3;
  localparam int IW = $clog2(N);

  logic            clk = 0;
  logic            rst_n = 0;
  logic [N-1:0]    slot_valid = '0;
  logic [N-1:0]    slot_ready = '0;
  logic [N*PW-1:0] slot_prio = '0;
  logic            issue_vld;
  logic [IW-1:0]   issue_slot;
  logic            idle;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] mrdy = '0;

  always #2 clk = ~clk;

  warp_issue_sel #(.NUM_SLOTS(N), .PRIO_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ready(slot_ready),
    .slot_prio(slot_prio), .issue_vld(issue_vld), .issue_slot(issue_slot), .idle(idle));

  function automatic int pick(input logic [N-1:0] v, input logic [N-1:0] r,
                              input logic [N*PW-1:0] p);
    int best = -1;
    int bp = -1;
    for (int i = 0; i < N; i++)
      if (v[i] && r[i] && int'(p[i*PW +: PW]) > bp) begin
        best = i;
        bp = int'(p[i*PW +: PW]);
      end
    return best;
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // lit: -1 no literal, -2 expect idle, >=0 expect that slot
  task automatic step(input logic [N-1:0] v, input logic [N-1:0] r,
                      input logic [N*PW-1:0] p, input string tag, input int lit);
    int e;
    @(negedge clk);
    slot_valid = v; slot_ready = r; slot_prio = p;
    #1;
    e = pick(v, mrdy, p);
    checks++;
    if (issue_vld !== (e >= 0) || idle !== (e < 0) ||
        int'(issue_slot) !== ((e >= 0) ? e : 0)) begin
      fails++;
      $display("FAIL %s: vld=%0b idle=%0b slot=%0d expected slot=%0d (-1 idle)",
               tag, issue_vld, idle, issue_slot, e);
    end
    if (lit != -1) begin
      checks++;
      if ((lit == -2 && !idle) || (lit >= 0 && (!issue_vld || int'(issue_slot) != lit))) begin
        fails++;
        $display("FAIL %s: vld=%0b slot=%0d expected literal %0d (-2 idle)",
                 tag, issue_vld, issue_slot, lit);
      end
    end
    @(posedge clk);
    if (rst_n) begin
      if (e >= 0) mrdy[e] = 1'b0;
      mrdy = mrdy | r;
    end
  endtask

  function automatic logic [N*PW-1:0] setp(input logic [N*PW-1:0] p, input int i, input int val);
    logic [N*PW-1:0] q = p;
    q[i*PW +: PW] = PW'(val);
    return q;
  endfunction

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    logic [N*PW-1:0] p;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state, R3 idle
    step('1, '0, '0, "R1", -2);
    step('1, '0, '0, "R3", -2);
    // R10 ready kept while invalid
    step('0, N'(1) << 5, '0, "R10", -2);
    step('0, '0, '0, "R4", -2);
    step(N'(1) << 5, '0, '0, "R10", 5);
    // R7 cleared after issue
    step('1, '0, '0, "R7", -2);
    // R6 tie and R9 back-to-back
    step('1, (N'(1) << 3) | (N'(1) << 9), '0, "R6", -2);
    step('1, '0, '0, "R6", 3);
    step('1, '0, '0, "R9", 9);
    step('1, '0, '0, "R7", -2);
    // R5 higher priority wins
    p = setp(setp('0, 1, 2), 20, 7);
    step('1, (N'(1) << 1) | (N'(1) << 20), p, "R5", -2);
    step('1, '0, p, "R5", 20);
    step('1, '0, p, "R9", 1);
    // R8 set wins over clear
    step('1, N'(1) << 7, '0, "R8", -2);
    step('1, N'(1) << 7, '0, "R8", 7);
    step('1, '0, '0, "R8", 7);
    step('1, '0, '0, "R7", -2);
    // random mix, R2 R4 R5 R6 R7 R8
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] v, r;
      for (int i = 0; i < N; i++) begin
        v[i] = ($urandom % 4) != 0;
        r[i] = ($urandom % 4) == 0;
        p[i*PW +: PW] = PW'($urandom % 4);
      end
      step(v, r, p, "R2", -1);
    end
    finish_run();
  end
endmodule